// File: doc/BRIEF.md
# Input-Supply Presence Detector

This block decides whether the converter's input rail is actually present before the regulation loop is allowed to start. After power-on reset is released and the shutdown request is inactive, it pulses the high-side gate with short probe pulses. It then watches a comparator flag that reports the switch node rising above its threshold. Each rising and each falling transition of that flag adds to a count. When enough transitions have been seen, the block stops probing and raises a level `ready` for the soft-start sequencer, together with a single-cycle strobe.

The controller is a four-state machine:

- `SP_IDLE`: gate low, nothing counted.
- `SP_PROBE`: pulses are issued and flag transitions are counted.
- `SP_ANNOUNCE`: one cycle; ready and strobe are high.
- `SP_READY`: ready held, no pulses.

The transitions are:

- **start**: `SP_IDLE` to `SP_PROBE` when `por_ok` is high and `shutdown` is low.
- **confirm**: `SP_PROBE` to `SP_ANNOUNCE` when the transition count reaches its target.
- **settle**: `SP_ANNOUNCE` to `SP_READY` unconditionally.
- **abort**: any state to `SP_IDLE` whenever `por_ok` is low or `shutdown` is high.

Abort has priority over every other transition.

The probe period and pulse width are parameters in clock cycles. The defaults, 10000 and 100, give a 10 kHz train at 1 % duty from a 100 MHz clock. The comparator flag passes through a synchronizer before its edges are detected.

Top module: `supply_probe_detect`

## Requirements
- R1: During reset, and while `por_ok` is low, `probe_gate`, `ready`, `ready_stb` and `busy` are all 0.
- R2: On the first rising clock edge where `por_ok` is 1 and `shutdown` is 0, the block enters probing. From that edge on, `busy` is 1 and `probe_gate` is 1.
- R3: While probing, `probe_gate` is high for WIDTH_CYC cycles and then low until PERIOD_CYC cycles have elapsed from the start of the pulse, and this repeats.
- R4: Both the rising and the falling transitions of `node_above` count as one each. The EDGE_TARGET-th counted transition (4 by default) makes `ready` and `ready_stb` 1 after the fourth rising clock edge following the clock edge at which that transition was applied. At the same edge, `busy` and `probe_gate` become 0. The count never exceeds EDGE_TARGET.
- R5: Fewer than EDGE_TARGET transitions never raise `ready`, however long probing lasts.
- R6: After ready is declared:
  - `ready_stb` is 1 for exactly one cycle.
  - `ready` stays 1 and `probe_gate` stays 0, regardless of further activity on `node_above`.
  - This holds until an abort.
- R7: When `shutdown` is 1:
  - All outputs are 0 after the next rising edge.
  - The transition count is cleared.
  - Probing does not start even with `por_ok` high.
  - After release, a full EDGE_TARGET new transitions are needed before `ready` rises again.
- R8: A low `por_ok` during probing or after ready returns all outputs to 0 after the next rising edge. A later high `por_ok` restarts probing from the beginning.
- R9: Transitions of `node_above` while the block is not probing are not counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| por_ok | input | 1 | Supply is above its power-on reset threshold |
| shutdown | input | 1 | Enable pin pulled low; aborts detection |
| node_above | input | 1 | Asynchronous comparator flag: switch node above its threshold |
| probe_gate | output | 1 | High-side gate probe pulse |
| ready | output | 1 | Input supply confirmed present (level) |
| ready_stb | output | 1 | One-cycle strobe when ready is declared |
| busy | output | 1 | Probing in progress |

## Verification
The hardest situation to reach is a count left over from an earlier attempt that wrongly survives into a new one.

The stimulus covers two such cases:
- **Idle activity, then probing.** The flag is toggled several times while the block is idle. Probing then starts, and only three more transitions are supplied. A count that kept the idle toggles would declare ready here.
- **Saturated count, then shutdown.** After a ready declaration has driven the count to saturation, a shutdown is applied and released. Again only three transitions follow, so any retained count shows up as an early `ready`.

The final transition of each attempt is timed against the clock so that the exact edge where `ready` and `ready_stb` appear is checked.

// File: rtl/supply_probe_pkg.sv
package supply_probe_pkg;

    typedef enum logic [1:0] {
        SP_IDLE     = 2'd0,
        SP_PROBE    = 2'd1,
        SP_ANNOUNCE = 2'd2,
        SP_READY    = 2'd3
    } sp_state_t;

endpackage

// File: rtl/sp_probe_timer.sv
module sp_probe_timer #(
    parameter int PERIOD_CYC = 10000,
    parameter int WIDTH_CYC  = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic pulse_on
);
    localparam int CW = (PERIOD_CYC > 1) ? $clog2(PERIOD_CYC) : 1;
    localparam logic [CW-1:0] LAST  = CW'(PERIOD_CYC - 1);
    localparam logic [CW-1:0] WIDTH = CW'(WIDTH_CYC);

    logic [CW-1:0] phase;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (!run) begin
            phase <= '0;
        end else if (phase == LAST) begin
            phase <= '0;
        end else begin
            phase <= phase + 1'b1;
        end
    end

    assign pulse_on = run && (phase < WIDTH);

    AST_TIMER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run)) |-> (phase == CW'($past(phase) + 1'b1) || phase == '0)); // R3

endmodule

// File: rtl/sp_flag_sync.sv
module sp_flag_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic flag_in,
    output logic toggled
);
    logic [STAGES-1:0] chain;
    logic              last_seen;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n)     chain[0] <= 1'b0;
                    else if (clear) chain[0] <= 1'b0;
                    else            chain[0] <= flag_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n)     chain[g] <= 1'b0;
                    else if (clear) chain[g] <= 1'b0;
                    else            chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     last_seen <= 1'b0;
        else if (clear) last_seen <= 1'b0;
        else            last_seen <= chain[STAGES-1];
    end

    assign toggled = chain[STAGES-1] ^ last_seen;

endmodule

// File: rtl/sp_edge_counter.sv
module sp_edge_counter #(
    parameter int TARGET = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic bump,
    output logic reached
);
    localparam int KW = $clog2(TARGET + 1);
    localparam logic [KW-1:0] TOP = KW'(TARGET);

    logic [KW-1:0] tally;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tally <= '0;
        end else if (clear) begin
            tally <= '0;
        end else if (bump && tally != TOP) begin
            tally <= tally + 1'b1;
        end
    end

    assign reached = (tally == TOP);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        tally <= TOP); // R4

endmodule

// File: rtl/supply_probe_detect.sv
module supply_probe_detect
    import supply_probe_pkg::*;
#(
    parameter int PERIOD_CYC  = 10000,
    parameter int WIDTH_CYC   = 100,
    parameter int SYNC_STAGES = 2,
    parameter int EDGE_TARGET = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic por_ok,
    input  logic shutdown,
    input  logic node_above,
    output logic probe_gate,
    output logic ready,
    output logic ready_stb,
    output logic busy
);
    sp_state_t state, state_nx;
    logic      abort;
    logic      probing;
    logic      pulse_on;
    logic      flag_toggled;
    logic      edges_reached;

    assign abort   = !por_ok || shutdown;
    assign probing = (state == SP_PROBE);

    sp_probe_timer #(
        .PERIOD_CYC (PERIOD_CYC),
        .WIDTH_CYC  (WIDTH_CYC)
    ) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (probing),
        .pulse_on (pulse_on)
    );

    sp_flag_sync #(
        .STAGES (SYNC_STAGES)
    ) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (!probing),
        .flag_in (node_above),
        .toggled (flag_toggled)
    );

    sp_edge_counter #(
        .TARGET (EDGE_TARGET)
    ) i_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (!probing),
        .bump    (flag_toggled),
        .reached (edges_reached)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            SP_IDLE:     if (!abort) state_nx = SP_PROBE;
            SP_PROBE:    if (abort) state_nx = SP_IDLE;
                         else if (edges_reached) state_nx = SP_ANNOUNCE;
            SP_ANNOUNCE: state_nx = abort ? SP_IDLE : SP_READY;
            SP_READY:    if (abort) state_nx = SP_IDLE;
            default:     state_nx = SP_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SP_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        probe_gate = 1'b0;
        ready      = 1'b0;
        ready_stb  = 1'b0;
        busy       = 1'b0;
        unique case (state)
            SP_IDLE: ;
            SP_PROBE: begin
                busy       = 1'b1;
                probe_gate = pulse_on;
            end
            SP_ANNOUNCE: begin
                ready     = 1'b1;
                ready_stb = 1'b1;
            end
            SP_READY: ready = 1'b1;
            default: ;
        endcase
    end

    AST_ABORT_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (state == SP_IDLE)); // R7
    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ready_stb |=> !ready_stb); // R6
    AST_READY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !abort) |=> ready); // R6
    AST_READY_NEEDS_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(edges_reached)); // R4
    AST_NO_GATE_AFTER_READY: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> !probe_gate); // R6

endmodule

// File: tb/test_supply_probe_detect.sv
module test_supply_probe_detect;

    logic clk = 1'b0;
    logic rst_n, por_ok, shutdown, node_above;
    logic probe_gate, ready, ready_stb, busy;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    supply_probe_detect #(
        .PERIOD_CYC  (20),
        .WIDTH_CYC   (3),
        .SYNC_STAGES (2),
        .EDGE_TARGET (4)
    ) i_supply_probe_detect (
        .clk        (clk),
        .rst_n      (rst_n),
        .por_ok     (por_ok),
        .shutdown   (shutdown),
        .node_above (node_above),
        .probe_gate (probe_gate),
        .ready      (ready),
        .ready_stb  (ready_stb),
        .busy       (busy)
    );

    typedef struct {
        logic  gate;
        logic  rdy;
        logic  stb;
        logic  bsy;
        bit    chk_gate;
        string tag;
    } exp_t;

    exp_t sb[$];

    // Driver: push what the outputs must be after the next rising edge.
    task automatic cyc(input logic g, input logic r, input logic s, input logic b,
                       input bit cg, input string tag);
        exp_t e;
        e.gate = g; e.rdy = r; e.stb = s; e.bsy = b; e.chk_gate = cg; e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
    endtask

    task automatic flip_probe(input int gap, input string tag);
        node_above = ~node_above;
        for (int i = 0; i < gap; i++) cyc(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, tag);
    endtask

    // Monitor: compare outputs shortly after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            while (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (ready !== e.rdy || ready_stb !== e.stb || busy !== e.bsy ||
                    (e.chk_gate && probe_gate !== e.gate)) begin
                    errors++;
                    $display("FAIL %s: got gate=%b ready=%b stb=%b busy=%b expected gate=%b ready=%b stb=%b busy=%b",
                             e.tag, probe_gate, ready, ready_stb, busy,
                             e.chk_gate ? e.gate : probe_gate, e.rdy, e.stb, e.bsy);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog (all requirements): got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; por_ok = 1'b0; shutdown = 1'b0; node_above = 1'b0;
        @(negedge clk);
        @(negedge clk);
        cyc(0, 0, 0, 0, 1, "R1 in reset");
        rst_n = 1'b1;
        for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, 1, "R1 por low");

        // R9: flag activity while idle must not be counted
        for (int i = 0; i < 6; i++) begin
            node_above = ~node_above;
            cyc(0, 0, 0, 0, 1, "R9 idle toggles");
        end

        // R2 / R3: probing starts and pulse waveform
        por_ok = 1'b1;
        for (int k = 1; k <= 21; k++)
            cyc((k <= 3) || (k == 21), 0, 0, 1, 1, (k == 1) ? "R2 probe start" : "R3 pulse train");

        // R5 / R9: three transitions are not enough
        for (int i = 0; i < 3; i++) flip_probe(5, "R5 below target");
        for (int i = 0; i < 30; i++) cyc(0, 0, 0, 1, 0, "R9 idle toggles not counted");

        // R4: fourth transition; ready after the fourth edge
        node_above = ~node_above;
        for (int i = 0; i < 3; i++) cyc(0, 0, 0, 1, 0, "R4 pipeline latency");
        cyc(0, 1, 1, 0, 1, "R4 ready declared");
        cyc(0, 1, 0, 0, 1, "R6 strobe one cycle");
        for (int i = 0; i < 6; i++) begin
            node_above = ~node_above;
            cyc(0, 1, 0, 0, 1, "R6 ready holds");
            cyc(0, 1, 0, 0, 1, "R6 ready holds");
        end

        // R7: shutdown aborts and clears
        shutdown = 1'b1;
        for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, 1, "R7 shutdown idle");
        shutdown = 1'b0;
        cyc(1, 0, 0, 1, 1, "R7 restart after shutdown");
        for (int i = 0; i < 3; i++) flip_probe(2, "R7 count cleared");
        for (int i = 0; i < 10; i++) cyc(0, 0, 0, 1, 0, "R7 count cleared");
        node_above = ~node_above;
        for (int i = 0; i < 3; i++) cyc(0, 0, 0, 1, 0, "R4 pipeline latency fast");
        cyc(0, 1, 1, 0, 1, "R4 ready declared fast");
        cyc(0, 1, 0, 0, 1, "R6 strobe one cycle");

        // R8: por drop after ready, then during probing
        por_ok = 1'b0;
        cyc(0, 0, 0, 0, 1, "R8 por drop after ready");
        cyc(0, 0, 0, 0, 1, "R8 por low");
        por_ok = 1'b1;
        cyc(1, 0, 0, 1, 1, "R8 probing restarts");
        cyc(1, 0, 0, 1, 1, "R8 probing restarts");
        por_ok = 1'b0;
        cyc(0, 0, 0, 0, 1, "R8 por drop during probe");

        // R7: shutdown blocks start even with por_ok high
        shutdown = 1'b1;
        por_ok = 1'b1;
        for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, 1, "R7 shutdown blocks start");
        shutdown = 1'b0;
        cyc(1, 0, 0, 1, 1, "R2 start after release");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule